// File: doc/BRIEF.md
# Logical Device I/O Range Checker

This block holds the activation and I/O conflict-check state of one logical device on a legacy expansion bus. Host software selects a configuration register by index and writes a byte to it. It programs up to eight 16-bit I/O base addresses, a device-enable bit and a range-check control byte. The block then answers host I/O reads by comparing the bus address against every programmed window.

When the device is enabled, a read inside any window raises a normal decode hit. When the device is disabled and range checking is on, the block drives one of two fixed test bytes on reads inside its windows. Software can then detect an overlap with another device before it turns the device on. A separate read-back port returns any register by index. A configuration-control reset pulse returns all of this state to its power-up value.

Top module: `ldev_io_check`

## Requirements
- R1: After the asynchronous reset every register reads back as 0x00, and `io_hit_o`, `io_drive_o` and `io_rdata_o` are all zero.
- R2: Index 0x30 is the enable register. Bit 0 turns the device on. Bits 7..1 always read back as zero.
- R3: Index 0x31 is the check-control register. Bit 1 enables range checking and bit 0 selects the test byte. Bits 7..2 always read back as zero.
- R4: Window i (0..7) has its base high byte [15:8] at index 0x60+2i and its low byte [7:0] at index 0x61+2i. Both bytes read back as written.
- R5: A window covers addresses base through base+RANGE_LEN-1 (RANGE_LEN defaults to 8) and does not wrap past 0xFFFF. A base of 0x0000 marks the window unused, so it matches nothing.
- R6: When the device is on, a host read inside any window sets `io_hit_o` to 1 in the same cycle. Reads outside every window give no hit.
- R7: When the device is off and checking is enabled, a host read inside any window sets `io_drive_o`. `io_rdata_o` is then 0x55 if the select bit is 1 and 0xAA if it is 0. In every other case `io_rdata_o` is 0x00.
- R8: While the device is on, check mode gives no test byte, only the normal hit. `io_hit_o` and `io_drive_o` are never high together.
- R9: A `cfg_reset_i` pulse clears the enable, check-control and all base registers at the next clock. It takes priority over a write in the same cycle.
- R10: A write to an index that is not defined above changes no state, and such an index reads back as 0x00.
- R11: Without `io_rd_i`, both `io_hit_o` and `io_drive_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_reset_i | input | 1 | Configuration-control reset pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 8 | Register index for writes |
| reg_wdata_i | input | 8 | Register write data |
| reg_rd_idx_i | input | 8 | Register index for read-back |
| reg_rdata_o | output | 8 | Read-back data (combinational) |
| io_rd_i | input | 1 | Host I/O read cycle |
| io_addr_i | input | 16 | Host I/O address |
| io_hit_o | output | 1 | Normal decode hit (device on) |
| io_drive_o | output | 1 | Test byte is being driven (check mode) |
| io_rdata_o | output | 8 | Test byte, zero when not driving |

## Verification
The assertions check on every cycle that a hit and a test-byte drive never occur together, that nothing responds without a host read, and that the data output holds only 0x55 or 0xAA while driving and 0x00 otherwise. They also check that reserved bits read as zero and that a configuration reset silences the decode one cycle later. Only the bench scenarios can show which addresses fall inside which windows. The same applies to the window edges at both ends and at the top of the address space, to unused zero bases, to byte placement in the base registers, and to writes at undefined indices being ignored.

// File: rtl/ldev_pkg.sv
package ldev_pkg;
  localparam logic [7:0] IDX_ENABLE   = 8'h30;
  localparam logic [7:0] IDX_CHECK    = 8'h31;
  localparam logic [7:0] IDX_BASE0    = 8'h60;
  localparam logic [7:0] PAT_SEL_ONE  = 8'h55;
  localparam logic [7:0] PAT_SEL_ZERO = 8'hAA;
endpackage

// File: rtl/ldev_regs.sv
module ldev_regs
  import ldev_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int ADDR_W     = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cfg_reset_i,
  input  logic                             we_i,
  input  logic [7:0]                       idx_i,
  input  logic [7:0]                       wdata_i,
  input  logic [7:0]                       rd_idx_i,
  output logic [7:0]                       rdata_o,
  output logic                             enable_o,
  output logic                             chk_en_o,
  output logic                             chk_sel_o,
  output logic [NUM_RANGES-1:0][ADDR_W-1:0] base_o
);
  localparam int NUM_BYTES = 2 * NUM_RANGES;

  logic [7:0] wr_off, rd_off;
  assign wr_off = idx_i - IDX_BASE0;
  assign rd_off = rd_idx_i - IDX_BASE0;

  logic wr_base, rd_base;
  assign wr_base = (idx_i >= IDX_BASE0) && (int'(wr_off) < NUM_BYTES);
  assign rd_base = (rd_idx_i >= IDX_BASE0) && (int'(rd_off) < NUM_BYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_o  <= 1'b0;
      chk_en_o  <= 1'b0;
      chk_sel_o <= 1'b0;
    end else if (cfg_reset_i) begin
      enable_o  <= 1'b0;
      chk_en_o  <= 1'b0;
      chk_sel_o <= 1'b0;
    end else if (we_i) begin
      if (idx_i == IDX_ENABLE) enable_o <= wdata_i[0];
      if (idx_i == IDX_CHECK) begin
        chk_en_o  <= wdata_i[1];
        chk_sel_o <= wdata_i[0];
      end
    end
  end

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[g] <= '0;
      end else if (cfg_reset_i) begin
        base_o[g] <= '0;
      end else if (we_i && wr_base && (int'(wr_off[7:1]) == g)) begin
        // even offset carries the upper byte
        if (!wr_off[0]) base_o[g][ADDR_W-1:8] <= wdata_i[ADDR_W-9:0];
        else            base_o[g][7:0]        <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (rd_idx_i == IDX_ENABLE) begin
      rdata_o = {7'b0, enable_o};
    end else if (rd_idx_i == IDX_CHECK) begin
      rdata_o = {6'b0, chk_en_o, chk_sel_o};
    end else if (rd_base) begin
      for (int k = 0; k < NUM_RANGES; k++) begin
        if (int'(rd_off[7:1]) == k)
          rdata_o = rd_off[0] ? base_o[k][7:0] : 8'(base_o[k][ADDR_W-1:8]);
      end
    end
  end
endmodule

// File: rtl/ldev_range_match.sv
module ldev_range_match #(
  parameter int ADDR_W    = 16,
  parameter int RANGE_LEN = 8
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              match_o
);
  // one extra bit keeps the window end from wrapping at the top of space
  localparam logic [ADDR_W:0] LEN = (ADDR_W+1)'(RANGE_LEN);

  logic [ADDR_W:0] lo, hi, a;
  assign lo = {1'b0, base_i};
  assign hi = lo + LEN;
  assign a  = {1'b0, addr_i};

  assign match_o = (base_i != '0) && (a >= lo) && (a < hi);
endmodule

// File: rtl/ldev_io_check.sv
module ldev_io_check
  import ldev_pkg::*;
#(
  parameter int NUM_RANGES = 8,
  parameter int ADDR_W     = 16,
  parameter int RANGE_LEN  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_reset_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_idx_i,
  input  logic [7:0]        reg_wdata_i,
  input  logic [7:0]        reg_rd_idx_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              io_rd_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  output logic              io_hit_o,
  output logic              io_drive_o,
  output logic [7:0]        io_rdata_o
);
  logic                              enable, chk_en, chk_sel;
  logic [NUM_RANGES-1:0][ADDR_W-1:0] base;
  logic [NUM_RANGES-1:0]             match;

  ldev_regs #(.NUM_RANGES(NUM_RANGES), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_reset_i(cfg_reset_i),
    .we_i       (reg_we_i),
    .idx_i      (reg_idx_i),
    .wdata_i    (reg_wdata_i),
    .rd_idx_i   (reg_rd_idx_i),
    .rdata_o    (reg_rdata_o),
    .enable_o   (enable),
    .chk_en_o   (chk_en),
    .chk_sel_o  (chk_sel),
    .base_o     (base)
  );

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_match
    ldev_range_match #(.ADDR_W(ADDR_W), .RANGE_LEN(RANGE_LEN)) u_match (
      .base_i (base[g]),
      .addr_i (io_addr_i),
      .match_o(match[g])
    );
  end

  logic in_window;
  assign in_window = io_rd_i && (|match);

  assign io_hit_o   = in_window && enable;
  assign io_drive_o = in_window && !enable && chk_en;  // check mode only while off
  assign io_rdata_o = !io_drive_o ? 8'h00 : (chk_sel ? PAT_SEL_ONE : PAT_SEL_ZERO);
endmodule

// File: rtl/ldev_io_check_sva.sv
module ldev_io_check_sva #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_reset_i,
  input logic              reg_we_i,
  input logic [7:0]        reg_idx_i,
  input logic [7:0]        reg_wdata_i,
  input logic [7:0]        reg_rd_idx_i,
  input logic [7:0]        reg_rdata_o,
  input logic              io_rd_i,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic              io_hit_o,
  input logic              io_drive_o,
  input logic [7:0]        io_rdata_o
);
  assert_enable_rsvd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_idx_i == 8'h30) |-> (reg_rdata_o[7:1] == 7'b0));

  assert_check_rsvd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_idx_i == 8'h31) |-> (reg_rdata_o[7:2] == 6'b0));

  assert_pattern_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_drive_o |-> (io_rdata_o == 8'h55 || io_rdata_o == 8'hAA));

  assert_quiet_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_drive_o |-> (io_rdata_o == 8'h00));

  assert_exclusive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_hit_o && io_drive_o));

  assert_cfg_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_reset_i |=> (!io_hit_o && !io_drive_o));

  assert_no_read_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_rd_i |-> (!io_hit_o && !io_drive_o));
endmodule

bind ldev_io_check ldev_io_check_sva #(.ADDR_W(ADDR_W)) u_sva (.*);

// File: tb/ldev_io_check_tb.sv
`timescale 1ns/1ps
module ldev_io_check_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_reset = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  idx = 8'h00, wdata = 8'h00, rd_idx = 8'h00;
  logic [7:0]  rdata;
  logic        io_rd = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        hit, drive;
  logic [7:0]  io_data;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ldev_io_check u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_reset_i(cfg_reset),
    .reg_we_i(we), .reg_idx_i(idx), .reg_wdata_i(wdata),
    .reg_rd_idx_i(rd_idx), .reg_rdata_o(rdata),
    .io_rd_i(io_rd), .io_addr_i(io_addr),
    .io_hit_o(hit), .io_drive_o(drive), .io_rdata_o(io_data)
  );

  typedef struct packed {
    logic        act, en, sel;
    logic [15:0] addr;
    logic        hit, drv;
    logic [7:0]  data;
  } vec_t;

  // windows: 0x0220, 0x0300, 0xFFF8, length 8
  localparam vec_t VECS [11] = '{
    '{1'b1, 1'b0, 1'b0, 16'h0220, 1'b1, 1'b0, 8'h00},  // R6 first
    '{1'b1, 1'b0, 1'b0, 16'h0227, 1'b1, 1'b0, 8'h00},  // R5 last
    '{1'b1, 1'b0, 1'b0, 16'h0228, 1'b0, 1'b0, 8'h00},  // R5 past end
    '{1'b1, 1'b0, 1'b0, 16'h021F, 1'b0, 1'b0, 8'h00},  // R5 below base
    '{1'b0, 1'b1, 1'b1, 16'h0222, 1'b0, 1'b1, 8'h55},  // R7 sel 1
    '{1'b0, 1'b1, 1'b0, 16'h0305, 1'b0, 1'b1, 8'hAA},  // R7 sel 0
    '{1'b0, 1'b0, 1'b1, 16'h0222, 1'b0, 1'b0, 8'h00},  // R7 check off
    '{1'b1, 1'b1, 1'b1, 16'h0222, 1'b1, 1'b0, 8'h00},  // R8
    '{1'b0, 1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b1, 8'hAA},  // R5 top of space
    '{1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 8'h00},  // R5 zero base unused
    '{1'b0, 1'b1, 1'b1, 16'h0100, 1'b0, 1'b0, 8'h00}   // R7 outside
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] i, input logic [7:0] d);
    @(negedge clk); we = 1'b1; idx = i; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] i, output logic [7:0] d);
    rd_idx = i; #1; d = rdata;
  endtask

  task automatic io(input logic [15:0] a);
    @(negedge clk); io_rd = 1'b1; io_addr = a; #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h30, d); chk("R1 enable", d, 8'h00);
    rd(8'h60, d); chk("R1 base", d, 8'h00);
    io(16'h0000); chk("R1 outputs", {hit, drive, io_data}, 10'h000);
    io_rd = 1'b0;

    // R4 base programming and byte placement
    wr(8'h60, 8'h02); wr(8'h61, 8'h20);
    wr(8'h66, 8'h03); wr(8'h67, 8'h00);
    wr(8'h6E, 8'hFF); wr(8'h6F, 8'hF8);
    rd(8'h60, d); chk("R4 hi0", d, 8'h02);
    rd(8'h61, d); chk("R4 lo0", d, 8'h20);
    rd(8'h6E, d); chk("R4 hi7", d, 8'hFF);
    rd(8'h6F, d); chk("R4 lo7", d, 8'hF8);

    // R2 / R3 reserved bits
    wr(8'h30, 8'hFE); rd(8'h30, d); chk("R2 rsvd", d, 8'h00);
    wr(8'h31, 8'hFF); rd(8'h31, d); chk("R3 rsvd", d, 8'h03);

    // R10 undefined index ignored
    wr(8'h32, 8'hFF); rd(8'h32, d); chk("R10 undef read", d, 8'h00);
    wr(8'h40, 8'h77); rd(8'h40, d); chk("R10 undef read2", d, 8'h00);
    rd(8'h31, d); chk("R10 check unchanged", d, 8'h03);

    // vector table
    foreach (VECS[n]) begin
      wr(8'h30, {7'b0, VECS[n].act});
      wr(8'h31, {6'b0, VECS[n].en, VECS[n].sel});
      io(VECS[n].addr);
      chk($sformatf("R6/R7/R8 vec%0d", n), {hit, drive, io_data},
          {VECS[n].hit, VECS[n].drv, VECS[n].data});
      io_rd = 1'b0;
    end

    // R11 no read strobe
    wr(8'h30, 8'h00); wr(8'h31, 8'h03);
    @(negedge clk); io_rd = 1'b0; io_addr = 16'h0222; #1;
    chk("R11 no strobe", {hit, drive, io_data}, 10'h000);
    wr(8'h30, 8'h01);
    @(negedge clk); io_rd = 1'b0; #1;
    chk("R11 no strobe active", {hit, drive}, 2'b00);

    // R9 config reset with a simultaneous write
    @(negedge clk); cfg_reset = 1'b1; we = 1'b1; idx = 8'h30; wdata = 8'h01;
    @(negedge clk); cfg_reset = 1'b0; we = 1'b0;
    rd(8'h30, d); chk("R9 enable", d, 8'h00);
    rd(8'h31, d); chk("R9 check", d, 8'h00);
    rd(8'h61, d); chk("R9 base", d, 8'h00);
    io(16'h0222); chk("R9 no decode", {hit, drive}, 2'b00);
    io_rd = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule